// File: doc/BRIEF.md
# Frame Line Checker and Data-Type Filter

This block sits on a camera stream after the packet headers have been decoded. Each input beat carries a data-type code, a pixel word, and single-cycle markers for frame start, frame end and line start. Pixel beats whose data type lies inside a configured inclusive window are forwarded one cycle later. All other beats are dropped.

During each frame the block counts lines. In line-sync mode a line is counted on every line-start marker. When the stream carries no line markers, a line is counted each time the configured horizontal size of accepted pixel beats has arrived.

At frame end, if checking is enabled, the counted lines are compared with a programmed line count. A sticky greater-than flag is raised when the programmed count is larger than the real count, and a less-than flag when it is smaller. A frame start that arrives before the previous frame's end raises a sticky discard flag. The flags are cleared by write-one pulses and are masked by per-flag enables to form the status outputs.

Top module: `frame_line_checker`

## Requirements
- R1: A beat with `in_valid` high and `cfg_dt_min <= in_dtype <= cfg_dt_max` (inclusive at both ends) appears on `out_valid`/`out_dtype`/`out_data` exactly one clock later, and beats leave in the order they arrived.
- R2: A beat whose data type lies outside the window never reaches the output and does not advance the line or beat counting.
- R3: With `cfg_has_ls` = 1, each `in_ls` pulse received between a frame start and its frame end counts as one line.
- R4: With `cfg_has_ls` = 0, a line is counted each time `cfg_hsize` in-window pixel beats have been received within the frame; `cfg_hsize` must be at least 1.
- R5: At a frame end inside a frame with `cfg_chk_en` = 1, flag bit 0 (greater-than) is set when `cfg_vlines` exceeds the counted lines, flag bit 1 (less-than) when it is below them, and neither when they are equal. The raw flag is visible one clock after the frame-end beat.
- R6: With `cfg_chk_en` = 0, a frame end sets neither bit 0 nor bit 1.
- R7: A frame start received while a frame is open sets flag bit 2 (discard) and restarts line counting for the new frame.
- R8: Raw flags are sticky until a 1 is applied on the matching `flag_clr` bit; when a set event and a clear occur in the same cycle, the flag stays set.
- R9: `flag_st` equals `flag_raw` ANDed bit-wise with `flag_en`.
- R10: A frame-end marker received while no frame is open changes no flag.
- R11: After reset, `out_valid` is 0 and all raw flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pixel beat valid |
| in_dtype | input | DT_W | Data-type code of the beat |
| in_data | input | DATA_W | Pixel word |
| in_fs | input | 1 | Frame-start marker |
| in_fe | input | 1 | Frame-end marker |
| in_ls | input | 1 | Line-start marker |
| cfg_dt_min | input | DT_W | Lower bound of the data-type window |
| cfg_dt_max | input | DT_W | Upper bound of the data-type window |
| cfg_vlines | input | CNT_W | Programmed lines per frame |
| cfg_hsize | input | CNT_W | Pixel beats per line when no line markers are used |
| cfg_has_ls | input | 1 | 1: the stream carries line markers |
| cfg_chk_en | input | 1 | Enable the line-count comparison |
| flag_en | input | 3 | Per-flag status enables |
| flag_clr | input | 3 | Write-one-to-clear pulses |
| out_valid | output | 1 | Forwarded beat valid |
| out_dtype | output | DT_W | Data type of the forwarded beat |
| out_data | output | DATA_W | Forwarded pixel word |
| flag_raw | output | 3 | Sticky raw flags: 0 greater-than, 1 less-than, 2 discard |
| flag_st | output | 3 | Masked status flags |

## Verification
The bench builds the block with its default widths: a 6-bit data type, 16-bit pixels and 12-bit counts. It programs small frames, such as three lines or a horizontal size of four beats, so that equal, short, long and cut-off frames all fit in a few hundred cycles. Window edges at 24 and 47 and their outside neighbours 23 and 48 are placed between counted beats. This exposes a filter that leaks into the counting as a wrong flag, not only as a wrong output beat.

// File: rtl/flc_pkg.sv
// Package: shared flag indices for the frame line checker.
package flc_pkg;
    localparam int NFLAG     = 3;
    localparam int FLAG_GT   = 0;
    localparam int FLAG_LT   = 1;
    localparam int FLAG_DISC = 2;
endpackage

// File: rtl/flc_dt_filter.sv
// Data-type window filter.
// Passes a beat one cycle later when its type lies inside [dt_min, dt_max].
// Assumes the window registers are held stable while beats are in flight.
module flc_dt_filter #(
    parameter int DATA_W = 16,
    parameter int DT_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DT_W-1:0]   in_dtype,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DT_W-1:0]   dt_min,
    input  logic [DT_W-1:0]   dt_max,
    output logic              accept,
    output logic              out_valid,
    output logic [DT_W-1:0]   out_dtype,
    output logic [DATA_W-1:0] out_data
);
    // Window test for the current beat.
    always_comb accept = in_valid && (in_dtype >= dt_min) && (in_dtype <= dt_max);

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_dtype <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_dtype <= in_dtype;
                out_data  <= in_data;
            end
        end
    end

    a_r1_window: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(dt_min) <= out_dtype && out_dtype <= $past(dt_max)));
endmodule

// File: rtl/flc_line_counter.sv
// Per-frame line counter and frame-end comparator.
// Counts lines from line markers, or from beat totals when markers are absent.
// At frame end it emits one-cycle set pulses for greater-than or less-than.
// A frame start inside an open frame emits a discard pulse.
// Assumes hsize >= 1 in beat-count mode.
module flc_line_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_fs,
    input  logic             in_fe,
    input  logic             in_ls,
    input  logic             beat_ok,
    input  logic             has_ls,
    input  logic             chk_en,
    input  logic [CNT_W-1:0] vlines,
    input  logic [CNT_W-1:0] hsize,
    output logic             set_gt,
    output logic             set_lt,
    output logic             set_disc
);
    localparam int LW = CNT_W + 1;
    localparam logic [LW-1:0] LMAX = {LW{1'b1}};

    logic             in_frame;
    logic [LW-1:0]    line_cnt;
    logic [CNT_W-1:0] beat_cnt;
    logic             beat_wrap;
    logic             line_inc;
    logic [LW-1:0]    lines_now;
    logic             end_ok;

    // Line event for this cycle and the saturated running total.
    always_comb begin
        beat_wrap = ({1'b0, beat_cnt} + 1'b1) == {1'b0, hsize};
        line_inc  = in_frame && (has_ls ? in_ls : (beat_ok && beat_wrap));
        lines_now = (line_inc && line_cnt != LMAX) ? line_cnt + 1'b1 : line_cnt;
        end_ok    = in_frame && in_fe;
        set_gt    = end_ok && chk_en && ({1'b0, vlines} > lines_now);
        set_lt    = end_ok && chk_en && ({1'b0, vlines} < lines_now);
        set_disc  = in_frame && in_fs && !in_fe;
    end

    // Frame state and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            line_cnt <= '0;
            beat_cnt <= '0;
        end else if (in_fs) begin
            in_frame <= 1'b1;
            line_cnt <= '0;
            beat_cnt <= '0;
        end else if (in_fe) begin
            in_frame <= 1'b0;
        end else if (in_frame) begin
            line_cnt <= lines_now;
            if (!has_ls && beat_ok)
                beat_cnt <= beat_wrap ? '0 : beat_cnt + 1'b1;
        end
    end

    a_r5_gt_lt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_gt && set_lt));
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_fs) |-> (line_cnt == '0 && beat_cnt == '0));
endmodule

// File: rtl/flc_flag_bank.sv
// Sticky flag bank with write-one-to-clear and enable masking.
// A set pulse takes priority over a clear pulse in the same cycle.
module flc_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] raw,
    output logic [N-1:0] st
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Sticky raw bit i.
        always_ff @(posedge clk) begin
            if (!rst_n) raw[i] <= 1'b0;
            else        raw[i] <= set[i] | (raw[i] & ~clr[i]);
        end

        a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(raw[i]) && !$past(clr[i])) |-> raw[i]);
        a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(clr[i]) && !$past(set[i])) |-> !raw[i]);
    end

    // Masked status view.
    always_comb st = raw & en;
endmodule

// File: rtl/frame_line_checker.sv
// Top: data-type filter, per-frame line checking and sticky flags.
// Markers are single-cycle pulses. Frame-start and frame-end markers carry no pixel.
module frame_line_checker
    import flc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DT_W   = 6,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DT_W-1:0]   in_dtype,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_fs,
    input  logic              in_fe,
    input  logic              in_ls,
    input  logic [DT_W-1:0]   cfg_dt_min,
    input  logic [DT_W-1:0]   cfg_dt_max,
    input  logic [CNT_W-1:0]  cfg_vlines,
    input  logic [CNT_W-1:0]  cfg_hsize,
    input  logic              cfg_has_ls,
    input  logic              cfg_chk_en,
    input  logic [2:0]        flag_en,
    input  logic [2:0]        flag_clr,
    output logic              out_valid,
    output logic [DT_W-1:0]   out_dtype,
    output logic [DATA_W-1:0] out_data,
    output logic [2:0]        flag_raw,
    output logic [2:0]        flag_st
);
    logic             accept;
    logic             set_gt, set_lt, set_disc;
    logic [NFLAG-1:0] set_vec;

    flc_dt_filter #(.DATA_W(DATA_W), .DT_W(DT_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dtype(in_dtype),
        .in_data(in_data), .dt_min(cfg_dt_min), .dt_max(cfg_dt_max),
        .accept(accept), .out_valid(out_valid), .out_dtype(out_dtype),
        .out_data(out_data)
    );

    flc_line_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .in_fs(in_fs), .in_fe(in_fe), .in_ls(in_ls),
        .beat_ok(accept), .has_ls(cfg_has_ls), .chk_en(cfg_chk_en),
        .vlines(cfg_vlines), .hsize(cfg_hsize),
        .set_gt(set_gt), .set_lt(set_lt), .set_disc(set_disc)
    );

    // Gather set pulses by flag index.
    always_comb begin
        set_vec            = '0;
        set_vec[FLAG_GT]   = set_gt;
        set_vec[FLAG_LT]   = set_lt;
        set_vec[FLAG_DISC] = set_disc;
    end

    flc_flag_bank #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(flag_clr), .en(flag_en),
        .raw(flag_raw), .st(flag_st)
    );

    a_r6_off_no_new: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_chk_en) && !$past(flag_raw[FLAG_GT]) && !$past(flag_raw[FLAG_LT]))
        |-> (!flag_raw[FLAG_GT] && !flag_raw[FLAG_LT]));
endmodule

// File: tb/sim_frame_line_checker.sv
module sim_frame_line_checker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 0, in_fs = 0, in_fe = 0, in_ls = 0;
    logic [5:0]  in_dtype = 0;
    logic [15:0] in_data = 0;
    logic [5:0]  cfg_dt_min = 6'd24, cfg_dt_max = 6'd47;
    logic [11:0] cfg_vlines = 12'd3, cfg_hsize = 12'd4;
    logic        cfg_has_ls = 1'b1, cfg_chk_en = 1'b1;
    logic [2:0]  flag_en = 3'b000, flag_clr = 3'b000;
    logic        out_valid;
    logic [5:0]  out_dtype;
    logic [15:0] out_data;
    logic [2:0]  flag_raw, flag_st;

    int n_tests = 0, n_fail = 0;
    logic [21:0] expq[$];
    logic [15:0] seq = 16'h100;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_line_checker u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dtype(in_dtype),
        .in_data(in_data), .in_fs(in_fs), .in_fe(in_fe), .in_ls(in_ls),
        .cfg_dt_min(cfg_dt_min), .cfg_dt_max(cfg_dt_max), .cfg_vlines(cfg_vlines),
        .cfg_hsize(cfg_hsize), .cfg_has_ls(cfg_has_ls), .cfg_chk_en(cfg_chk_en),
        .flag_en(flag_en), .flag_clr(flag_clr), .out_valid(out_valid),
        .out_dtype(out_dtype), .out_data(out_data), .flag_raw(flag_raw),
        .flag_st(flag_st)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every forwarded beat must match the head of the queue (R1, R2).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) chk("R2 unexpected beat", {10'd0, out_dtype, out_data}, 32'hffff_ffff);
            else chk("R1 beat", {10'd0, out_dtype, out_data}, {10'd0, expq.pop_front()});
        end
    end

    // Driver: one cycle of stimulus, held from a falling edge.
    task automatic drive(input logic v, input logic [5:0] dt, input logic fs,
                         input logic fe, input logic ls, input logic [2:0] clr);
        @(negedge clk);
        in_valid = v; in_dtype = dt; in_data = seq; in_fs = fs; in_fe = fe;
        in_ls = ls; flag_clr = clr;
        if (v && dt >= cfg_dt_min && dt <= cfg_dt_max) expq.push_back({dt, seq});
        seq++;
    endtask
    task automatic idle(); drive(0, 0, 0, 0, 0, 3'b000); endtask
    task automatic pix(input logic [5:0] dt); drive(1, dt, 0, 0, 0, 3'b000); endtask
    task automatic fs(); drive(0, 0, 1, 0, 0, 3'b000); endtask
    task automatic fe(); drive(0, 0, 0, 1, 0, 3'b000); endtask
    task automatic ls(); drive(0, 0, 0, 0, 1, 3'b000); endtask
    task automatic clear(input logic [2:0] c); drive(0, 0, 0, 0, 0, c); idle(); endtask

    // Line-marker frame with n lines, each with in- and out-of-window beats.
    task automatic ls_frame(input int n);
        fs();
        for (int i = 0; i < n; i++) begin
            ls(); pix(6'd24); pix(6'd23); pix(6'd47); pix(6'd48); pix(6'd30);
        end
        fe(); idle();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 out_valid", out_valid, 0);
        chk("R11 raw", flag_raw, 0);
        rst_n = 1'b1;
        idle();

        ls_frame(3);                       // R3 R5 equal count
        chk("R5 equal no flag", flag_raw, 3'b000);
        ls_frame(2);                       // programmed 3 > 2
        chk("R5 gt", flag_raw, 3'b001);
        chk("R9 masked", flag_st, 3'b000);
        flag_en = 3'b011; idle();
        chk("R9 enabled", flag_st, 3'b001);
        ls_frame(5);                       // sticky: gt kept, lt added
        chk("R8 sticky + R5 lt", flag_raw, 3'b011);
        clear(3'b001);
        chk("R8 clear gt", flag_raw, 3'b010);

        fs(); for (int i = 0; i < 4; i++) ls();
        drive(0, 0, 0, 1, 0, 3'b010); idle();   // set and clear same cycle
        chk("R8 set wins", flag_raw, 3'b010);
        clear(3'b010);
        chk("R8 clear lt", flag_raw, 3'b000);

        cfg_chk_en = 1'b0; ls_frame(1);
        chk("R6 check off", flag_raw, 3'b000);
        cfg_chk_en = 1'b1;

        // R4 beat-count mode, hsize 4, vlines 2; markers must be ignored
        cfg_has_ls = 1'b0; cfg_vlines = 12'd2;
        fs(); ls();
        for (int i = 0; i < 8; i++) begin pix(6'd40); pix(6'd50); end
        fe(); idle();
        chk("R4 R2 eight beats two lines", flag_raw, 3'b000);
        fs(); for (int i = 0; i < 7; i++) begin pix(6'd25); pix(6'd10); end
        fe(); idle();
        chk("R4 seven beats one line", flag_raw, 3'b001);
        clear(3'b001);
        fs(); for (int i = 0; i < 12; i++) pix(6'd47);
        fe(); idle();
        chk("R4 twelve beats three lines", flag_raw, 3'b010);
        clear(3'b010);

        // R7 cut frame then a clean one
        cfg_has_ls = 1'b1; cfg_vlines = 12'd3;
        fs(); ls(); ls(); pix(6'd30);
        ls_frame(3);
        chk("R7 discard, restart counts", flag_raw, 3'b100);
        flag_en = 3'b100; idle();
        chk("R9 discard status", flag_st, 3'b100);
        clear(3'b100);

        // R10 frame end with no open frame
        fe(); idle(); fe(); idle();
        chk("R10 stray end", flag_raw, 3'b000);

        repeat (3) idle();
        chk("R1 queue drained", expq.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule